// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Dispatcher Front End

This block is the register-facing side of a scatter-gather DMA engine. Software reaches it through one simple register bus split into three windows. The control/status window holds the engine controls, the sticky status flags, the fill levels and the sequence numbers. The descriptor window stages an eight-word descriptor one word at a time. The response window drains completion records. A descriptor enters the descriptor queue as a single entry, and only when its last word is written with the commit flag set. Until then, word writes change nothing but the staging registers.

A small data-mover model stands in for the real read and write engines. It takes one descriptor from the queue, holds it for a fixed number of cycles and then pushes a response into the response queue. The response holds the byte count and a status code. The model uses the low byte of the descriptor's control word as an injected error code. It reports early termination when control bit 24 is set. Completions and errors can raise a level interrupt. The interrupt status bit is cleared by writing one to it.

Top module: `dma_dispatch_front`

## Requirements
- R1: Writes to descriptor words 0..6 (length at word 2, sequence field at word 3 bits 15:0), and a write to word 7 with bit 31 clear, only stage data. The descriptor queue fill level does not change.
- R2: A write to descriptor word 7 with bit 31 set commits the staged words together with that control word as one queue entry. CSR offset 2 reports the descriptor queue level in both halves: bits 31:16 and bits 15:0.
- R3: A commit while the queue holds DESC_DEPTH entries is dropped. The queue keeps its earlier entries in order. Status bit 2 (queue full) is high while the queue is full.
- R4: The mover takes descriptors in commit order. Each one completes MOVER_DELAY cycles after it is taken. Its response reports the length as the byte count. Response status bits 7:0 carry control bits 7:0, and response status bit 8 carries control bit 24.
- R5: Response window word 0 gives the byte count and word 1 gives the status. An entry is removed only by a status read that follows a byte-count read of the same entry. A status read alone removes nothing. Reads from an empty response queue return 0. CSR offset 3 gives the response queue level.
- R6: CSR offset 0 gives the status word: bit 0 busy, 1 descriptor queue empty, 2 descriptor queue full, 3 response queue empty, 4 response queue full, 5 stopped, 6 resetting, 7 stopped on error, 8 stopped on early end, 9 interrupt. Busy is high while the descriptor queue is non-empty or the mover holds a descriptor.
- R7: Status bit 9 sets when a response is pushed for a descriptor that has control bit 14 set, or whose error code ANDed with control bits 23:16 is non-zero. Writing 1 to status bit 9 clears it. The irq output equals status bit 9 AND control bit 4.
- R8: With control bit 2 set, a response with a non-zero error code sets status bit 7. With control bit 3 set, an early-end response sets status bit 8. While either bit is set, no descriptor is taken. Writing 1 to the bit clears it and lets the mover resume.
- R9: Control bit 0 (stop) and control bit 5 (stop fetching) each keep the mover from taking descriptors. Status bit 5 is high while any such hold is active and the mover is idle.
- R10: Writing control bit 1 sets status bit 6 for RESET_CYCLES cycles. During that time the queues, the staging registers, the mover, the sticky status bits and the control register are cleared, and other writes are ignored. Afterwards bit 6 clears by itself.
- R11: CSR offset 4 gives, in bits 15:0, the sequence field of the descriptor most recently taken by the mover. Bits 31:16 give the sequence field of the descriptor most recently completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a response status read can pop the queue |
| bus_win | input | 2 | Window select: 0 CSR, 1 descriptor, 2 response |
| bus_addr | input | 3 | Word offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check the following. The descriptor level never exceeds its depth. Busy covers a non-empty queue. A flush empties the queue one cycle after it starts. A response pop always follows a byte-count read. The interrupt status only rises right after a response push, and the irq pin never rises without it. A sticky error stop blocks every take. The bench scenarios show the rest: the atomic commit behaviour, the dropped commit at full depth with order kept, the response field mapping and the mover delay, the stop and resume sequences, the interrupt gating, the sequence numbers, and the self-clearing reset flag.

// File: rtl/dmadp_pkg.sv
package dmadp_pkg;
  localparam int DESC_WORDS = 8;
  typedef logic [DESC_WORDS-1:0][31:0] desc_t;

  // descriptor word slots the dispatcher itself decodes
  localparam int W_LEN  = 2;
  localparam int W_SEQ  = 3;
  localparam int W_CTRL = 7;

  // descriptor control word bits
  localparam int DC_CMP_IRQ    = 14;
  localparam int DC_EARLY_DONE = 24;
  localparam int DC_GO         = 31;

  // control register bits
  localparam int CT_STOP       = 0;
  localparam int CT_RESET      = 1;
  localparam int CT_STOP_ERR   = 2;
  localparam int CT_STOP_EARLY = 3;
  localparam int CT_GIE        = 4;
  localparam int CT_STOP_FETCH = 5;

  // status register bits
  localparam int ST_BUSY       = 0;
  localparam int ST_D_EMPTY    = 1;
  localparam int ST_D_FULL     = 2;
  localparam int ST_R_EMPTY    = 3;
  localparam int ST_R_FULL     = 4;
  localparam int ST_STOPPED    = 5;
  localparam int ST_RESETTING  = 6;
  localparam int ST_STOP_ERR   = 7;
  localparam int ST_STOP_EARLY = 8;
  localparam int ST_IRQ        = 9;

  localparam logic [1:0] WIN_CSR  = 2'd0;
  localparam logic [1:0] WIN_DESC = 2'd1;
  localparam logic [1:0] WIN_RESP = 2'd2;

  typedef struct packed {
    logic [31:0] bytes;
    logic        early;
    logic [7:0]  err;
  } resp_t;
endpackage

// File: rtl/dmadp_fifo.sv
module dmadp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign rdata   = mem[rd_ptr_q];
  assign count   = cnt_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_d = (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wdata;
  end
endmodule

// File: rtl/dmadp_mover.sv
module dmadp_mover
  import dmadp_pkg::*;
#(
  parameter int DELAY = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        halt,
  input  logic        desc_avail,
  input  desc_t       desc_in,
  output logic        desc_pop,
  input  logic        resp_full,
  output logic        resp_push,
  output resp_t       resp_out,
  output logic        irq_req,
  output logic        active,
  output logic [15:0] rd_seq,
  output logic [15:0] wr_seq
);
  localparam int DW = (DELAY > 1) ? $clog2(DELAY) : 1;

  logic          act_q, act_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [31:0]   len_q, len_d, ctl_q, ctl_d;
  logic [15:0]   rseq_q, rseq_d, wseq_q, wseq_d;
  logic          unused_desc_words;

  assign unused_desc_words = ^{desc_in[0], desc_in[1], desc_in[4], desc_in[5],
                               desc_in[6], desc_in[W_SEQ][31:16]};

  assign desc_pop  = !act_q && desc_avail && !halt && !clr;
  assign resp_push = act_q && (cnt_q == '0) && !resp_full && !clr;

  assign resp_out.bytes = len_q;
  assign resp_out.err   = ctl_q[7:0];
  assign resp_out.early = ctl_q[DC_EARLY_DONE];
  assign irq_req        = ctl_q[DC_CMP_IRQ] || (|(ctl_q[7:0] & ctl_q[23:16]));
  assign active         = act_q;
  assign rd_seq         = rseq_q;
  assign wr_seq         = wseq_q;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    ctl_d  = ctl_q;
    rseq_d = rseq_q;
    wseq_d = wseq_q;
    if (clr) begin
      act_d  = 1'b0;
      cnt_d  = '0;
      rseq_d = '0;
      wseq_d = '0;
    end else if (desc_pop) begin
      act_d  = 1'b1;
      cnt_d  = DW'(DELAY-1);
      len_d  = desc_in[W_LEN];
      ctl_d  = desc_in[W_CTRL];
      rseq_d = desc_in[W_SEQ][15:0];
    end else if (act_q) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else if (resp_push) begin
        act_d  = 1'b0;
        wseq_d = rseq_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      ctl_q  <= '0;
      rseq_q <= '0;
      wseq_q <= '0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      ctl_q  <= ctl_d;
      rseq_q <= rseq_d;
      wseq_q <= wseq_d;
    end
  end
endmodule

// File: rtl/dma_dispatch_front.sv
module dma_dispatch_front
  import dmadp_pkg::*;
#(
  parameter int DESC_DEPTH   = 16,
  parameter int RESP_DEPTH   = 16,
  parameter int MOVER_DELAY  = 6,
  parameter int RESET_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_win,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int DCW = $clog2(DESC_DEPTH+1);
  localparam int RCW = $clog2(RESP_DEPTH+1);
  localparam int RW  = $bits(resp_t);
  localparam int TW  = (RESET_CYCLES > 1) ? $clog2(RESET_CYCLES) : 1;

  // register state
  logic [DESC_WORDS-2:0][31:0] stage_q, stage_d;
  logic [5:0]                  ctl_q, ctl_d;
  logic                        serr_q, serr_d, searly_q, searly_d, sirq_q, sirq_d;
  logic                        resetting_q, resetting_d;
  logic [TW-1:0]               rtim_q, rtim_d;
  logic                        bseen_q, bseen_d;

  // interconnect
  logic            csr_wr, desc_wr, commit;
  logic            d_full, d_empty, d_pop, r_full, r_empty, r_push, r_pop;
  logic [DCW-1:0]  d_cnt;
  logic [RCW-1:0]  r_cnt;
  desc_t           d_in, d_out;
  resp_t           r_in, r_out;
  logic [RW-1:0]   r_out_bits;
  logic            irq_req, mv_active, halt, busy, stopped;
  logic [15:0]     rd_seq, wr_seq;
  logic [31:0]     status_w;

  assign csr_wr  = bus_wr && (bus_win == WIN_CSR) && !resetting_q;
  assign desc_wr = bus_wr && (bus_win == WIN_DESC) && !resetting_q;
  assign commit  = desc_wr && (bus_addr == 3'(W_CTRL)) && bus_wdata[DC_GO];
  assign d_in    = {bus_wdata, stage_q};
  assign r_out   = resp_t'(r_out_bits);
  assign r_pop   = bus_rd && (bus_win == WIN_RESP) && (bus_addr == 3'd1) && bseen_q && !r_empty;

  assign halt    = ctl_q[CT_STOP] || ctl_q[CT_STOP_FETCH] || serr_q || searly_q || resetting_q;
  assign busy    = !d_empty || mv_active;
  assign stopped = halt && !resetting_q && !mv_active;
  assign irq     = sirq_q && ctl_q[CT_GIE];

  dmadp_fifo #(.W($bits(desc_t)), .DEPTH(DESC_DEPTH)) desc_q_i (
    .clk(clk), .rst_n(rst_n), .clr(resetting_q),
    .push(commit), .wdata(d_in), .pop(d_pop), .rdata(d_out),
    .count(d_cnt), .full(d_full), .empty(d_empty)
  );

  dmadp_fifo #(.W(RW), .DEPTH(RESP_DEPTH)) resp_q_i (
    .clk(clk), .rst_n(rst_n), .clr(resetting_q),
    .push(r_push), .wdata(r_in), .pop(r_pop), .rdata(r_out_bits),
    .count(r_cnt), .full(r_full), .empty(r_empty)
  );

  dmadp_mover #(.DELAY(MOVER_DELAY)) mover_i (
    .clk(clk), .rst_n(rst_n), .clr(resetting_q), .halt(halt),
    .desc_avail(!d_empty), .desc_in(d_out), .desc_pop(d_pop),
    .resp_full(r_full), .resp_push(r_push), .resp_out(r_in),
    .irq_req(irq_req), .active(mv_active), .rd_seq(rd_seq), .wr_seq(wr_seq)
  );

  // next state
  always_comb begin
    stage_d     = stage_q;
    ctl_d       = ctl_q;
    serr_d      = serr_q;
    searly_d    = searly_q;
    sirq_d      = sirq_q;
    resetting_d = resetting_q;
    rtim_d      = rtim_q;
    bseen_d     = bseen_q;

    if (resetting_q) begin
      stage_d  = '0;
      serr_d   = 1'b0;
      searly_d = 1'b0;
      sirq_d   = 1'b0;
      bseen_d  = 1'b0;
      if (rtim_q == '0) resetting_d = 1'b0;
      else              rtim_d = rtim_q - 1'b1;
    end else begin
      if (desc_wr && (bus_addr != 3'(W_CTRL)))
        stage_d[bus_addr] = bus_wdata;
      if (csr_wr && (bus_addr == 3'd1)) begin
        if (bus_wdata[CT_RESET]) begin
          ctl_d       = '0;
          resetting_d = 1'b1;
          rtim_d      = TW'(RESET_CYCLES-1);
        end else begin
          ctl_d = bus_wdata[5:0];
        end
      end
      if (csr_wr && (bus_addr == 3'd0)) begin
        if (bus_wdata[ST_STOP_ERR])   serr_d   = 1'b0;
        if (bus_wdata[ST_STOP_EARLY]) searly_d = 1'b0;
        if (bus_wdata[ST_IRQ])        sirq_d   = 1'b0;
      end
      if (r_push) begin
        if (irq_req) sirq_d = 1'b1;
        if (ctl_q[CT_STOP_ERR] && (r_in.err != 8'd0)) serr_d = 1'b1;
        if (ctl_q[CT_STOP_EARLY] && r_in.early)       searly_d = 1'b1;
      end
      if (bus_rd && (bus_win == WIN_RESP) && !r_empty) begin
        if (bus_addr == 3'd0) bseen_d = 1'b1;
      end
      if (r_pop) bseen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q     <= '0;
      ctl_q       <= '0;
      serr_q      <= 1'b0;
      searly_q    <= 1'b0;
      sirq_q      <= 1'b0;
      resetting_q <= 1'b0;
      rtim_q      <= '0;
      bseen_q     <= 1'b0;
    end else begin
      stage_q     <= stage_d;
      ctl_q       <= ctl_d;
      serr_q      <= serr_d;
      searly_q    <= searly_d;
      sirq_q      <= sirq_d;
      resetting_q <= resetting_d;
      rtim_q      <= rtim_d;
      bseen_q     <= bseen_d;
    end
  end

  // read path
  always_comb begin
    status_w                = '0;
    status_w[ST_BUSY]       = busy;
    status_w[ST_D_EMPTY]    = d_empty;
    status_w[ST_D_FULL]     = d_full;
    status_w[ST_R_EMPTY]    = r_empty;
    status_w[ST_R_FULL]     = r_full;
    status_w[ST_STOPPED]    = stopped;
    status_w[ST_RESETTING]  = resetting_q;
    status_w[ST_STOP_ERR]   = serr_q;
    status_w[ST_STOP_EARLY] = searly_q;
    status_w[ST_IRQ]        = sirq_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_win)
        WIN_CSR: begin
          case (bus_addr)
            3'd0:    bus_rdata = status_w;
            3'd1:    bus_rdata = {26'd0, ctl_q};
            3'd2:    bus_rdata = {16'(d_cnt), 16'(d_cnt)};
            3'd3:    bus_rdata = {16'd0, 16'(r_cnt)};
            3'd4:    bus_rdata = {wr_seq, rd_seq};
            default: bus_rdata = '0;
          endcase
        end
        WIN_DESC: bus_rdata = (bus_addr == 3'(W_CTRL)) ? '0 : stage_q[bus_addr];
        WIN_RESP: begin
          if (!r_empty) begin
            if (bus_addr == 3'd0)      bus_rdata = r_out.bytes;
            else if (bus_addr == 3'd1) bus_rdata = {23'd0, r_out.early, r_out.err};
          end
        end
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dmadp_checker.sv
module dmadp_checker #(
  parameter int DESC_DEPTH = 16,
  parameter int DCW        = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic [DCW-1:0] d_cnt,
  input logic           busy,
  input logic           resetting,
  input logic           r_push,
  input logic           r_pop,
  input logic           bseen,
  input logic           sirq,
  input logic           irq,
  input logic           serr,
  input logic           d_pop
);
  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    d_cnt <= DCW'(DESC_DEPTH));

  assert_busy_cover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_cnt != '0) |-> busy);

  assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |=> (d_cnt == '0));

  assert_pop_after_bytes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    r_pop |-> bseen);

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sirq) |-> $past(r_push));

  assert_irq_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sirq);

  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    serr |-> !d_pop);
endmodule

bind dma_dispatch_front dmadp_checker #(.DESC_DEPTH(DESC_DEPTH), .DCW(DCW)) chk_i (
  .clk(clk), .rst_n(rst_n), .d_cnt(d_cnt), .busy(busy), .resetting(resetting_q),
  .r_push(r_push), .r_pop(r_pop), .bseen(bseen_q), .sirq(sirq_q), .irq(irq),
  .serr(serr_q), .d_pop(d_pop)
);

// File: tb/dma_dispatch_front_tb.sv
module dma_dispatch_front_tb_top;
  localparam int DEPTH = 16;
  localparam int DELAY = 6;
  localparam int RCYC  = 4;

  logic        clk, rst_n, bus_wr, bus_rd, irq;
  logic [1:0]  bus_win;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int checks, errors;
  bit done;

  dma_dispatch_front #(.DESC_DEPTH(DEPTH), .RESP_DEPTH(DEPTH),
                       .MOVER_DELAY(DELAY), .RESET_CYCLES(RCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_win(bus_win),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] st(bit busy, bit de, bit df, bit re, bit rf, bit stp,
                                     bit rs, bit se, bit see, bit iq);
    return {22'd0, iq, see, se, rs, stp, rf, re, df, de, busy};
  endfunction

  function automatic logic [31:0] resp_status(logic [31:0] ctrl);
    return {23'd0, ctrl[24], ctrl[7:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] w, logic [2:0] a, logic [31:0] d);
    bus_win = w; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] w, logic [2:0] a, output logic [31:0] d);
    bus_win = w; bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic stage(logic [31:0] len, logic [15:0] seq);
    for (int i = 0; i < 7; i++)
      wr(2'd1, 3'(i), (i == 2) ? len : (i == 3) ? {16'h0, seq} : 32'h1000 * (i + 1));
  endtask

  task automatic submit(logic [31:0] len, logic [15:0] seq, logic [31:0] ctrl);
    stage(len, seq);
    wr(2'd1, 3'd7, ctrl | 32'h8000_0000);
  endtask

  task automatic take_resp(string req, logic [31:0] len, logic [31:0] stat);
    logic [31:0] v;
    rd(2'd2, 3'd0, v); check(req, v, len);
    rd(2'd2, 3'd1, v); check(req, v, stat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, lens [DEPTH+2];
    logic [31:0] ctrl, len;
    logic [15:0] seq;
    checks = 0; errors = 0; done = 0;
    v = $urandom(32'h5EED_0042);
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_win = 0; bus_addr = 0; bus_wdata = 0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // reset state (R6)
    rd(2'd0, 3'd0, v); check("R6 reset status", v, st(0,1,0,1,0,0,0,0,0,0));
    rd(2'd0, 3'd1, v); check("R6 reset control", v, 32'd0);
    check("R7 reset irq", {31'd0, irq}, 32'd0);
    rd(2'd2, 3'd0, v); check("R5 empty read", v, 32'd0);

    // staging without commit (R1)
    stage(32'd40, 16'h0011);
    wr(2'd1, 3'd7, 32'h0000_4000);
    idle(2);
    rd(2'd0, 3'd2, v); check("R1 no commit fill", v, 32'd0);
    rd(2'd1, 3'd2, v); check("R1 staged length", v, 32'd40);

    // single transfer with completion irq (R2, R4, R7, R11)
    wr(2'd0, 3'd1, 32'h10);
    submit(32'd256, 16'h00A5, 32'h0000_4000);
    rd(2'd0, 3'd2, v); check("R2 fill after commit", v, 32'h0001_0001);
    idle(DELAY + 3);
    rd(2'd0, 3'd0, v); check("R6 status after completion", v, st(0,1,0,0,0,0,0,0,0,1));
    check("R7 irq raised", {31'd0, irq}, 32'd1);
    rd(2'd0, 3'd3, v); check("R5 resp fill", v, 32'd1);
    rd(2'd0, 3'd4, v); check("R11 sequence numbers", v, 32'h00A5_00A5);
    rd(2'd2, 3'd1, v); check("R5 status alone", v, 32'd0);
    rd(2'd0, 3'd3, v); check("R5 status alone no pop", v, 32'd1);
    take_resp("R4 response", 32'd256, 32'd0);
    rd(2'd0, 3'd3, v); check("R5 popped", v, 32'd0);
    wr(2'd0, 3'd0, 32'h200);
    check("R7 irq cleared", {31'd0, irq}, 32'd0);

    // random transfers (R4, R11)
    for (int k = 0; k < 4; k++) begin
      len  = $urandom;
      seq  = 16'($urandom);
      ctrl = {7'd0, 1'($urandom), 24'd0};
      wr(2'd0, 3'd1, 32'h0);
      submit(len, seq, ctrl);
      idle(DELAY + 3);
      rd(2'd0, 3'd4, v); check("R11 random seq", v, {seq, seq});
      take_resp("R4 random response", len, resp_status(ctrl));
    end

    // interrupt gating (R7)
    wr(2'd0, 3'd1, 32'h0);
    submit(32'd8, 16'h1, 32'h0000_4000);
    idle(DELAY + 3);
    check("R7 gated irq low", {31'd0, irq}, 32'd0);
    rd(2'd0, 3'd0, v); check("R7 status irq set", {31'd0, v[9]}, 32'd1);
    wr(2'd0, 3'd1, 32'h10);
    check("R7 gated irq high", {31'd0, irq}, 32'd1);
    wr(2'd0, 3'd0, 32'h200);
    take_resp("R4 gated response", 32'd8, 32'd0);

    // stop on error (R8, R7 error mask)
    wr(2'd0, 3'd1, 32'h14);
    submit(32'd32, 16'h2, 32'h00FF_0005);
    submit(32'd64, 16'h3, 32'h0);
    idle(DELAY + 3);
    rd(2'd0, 3'd0, v); check("R8 stop on error status", v, st(1,0,0,0,0,1,0,1,0,1));
    rd(2'd0, 3'd2, v); check("R8 second held", v, 32'h0001_0001);
    take_resp("R8 error response", 32'd32, 32'd5);
    wr(2'd0, 3'd0, 32'h280);
    idle(DELAY + 3);
    take_resp("R8 resumed response", 32'd64, 32'd0);
    check("R7 irq after clear", {31'd0, irq}, 32'd0);

    // stop on early end (R8, R4 early bit)
    wr(2'd0, 3'd1, 32'h08);
    submit(32'd12, 16'h4, 32'h0100_0000);
    idle(DELAY + 3);
    rd(2'd0, 3'd0, v); check("R8 early stop status", v, st(0,1,0,0,0,1,0,0,1,0));
    wr(2'd0, 3'd0, 32'h100);
    take_resp("R4 early response", 32'd12, 32'h100);

    // full queue with stop (R3, R9)
    wr(2'd0, 3'd1, 32'h01);
    for (int k = 0; k < DEPTH + 2; k++) begin
      lens[k] = $urandom;
      submit(lens[k], 16'(k), 32'h0);
    end
    rd(2'd0, 3'd2, v); check("R3 fill at depth", v, {16'(DEPTH), 16'(DEPTH)});
    rd(2'd0, 3'd0, v); check("R3 R9 full status", v, st(1,0,1,1,0,1,0,0,0,0));
    wr(2'd0, 3'd1, 32'h00);
    idle(DEPTH * (DELAY + 1) + 20);
    rd(2'd0, 3'd0, v); check("R5 resp full status", v, st(0,1,0,0,1,0,0,0,0,0));
    for (int k = 0; k < DEPTH; k++) take_resp("R3 order kept", lens[k], 32'd0);
    rd(2'd0, 3'd3, v); check("R3 dropped commits absent", v, 32'd0);

    // stop fetching then reset (R9, R10)
    wr(2'd0, 3'd1, 32'h20);
    submit(32'd4, 16'h7, 32'h0);
    submit(32'd4, 16'h8, 32'h0);
    idle(DELAY + 3);
    rd(2'd0, 3'd0, v); check("R9 stop fetch status", v, st(1,0,0,1,0,1,0,0,0,0));
    wr(2'd0, 3'd1, 32'h02);
    rd(2'd0, 3'd0, v); check("R10 resetting flag", {31'd0, v[6]}, 32'd1);
    idle(RCYC + 2);
    rd(2'd0, 3'd0, v); check("R10 status after reset", v, st(0,1,0,1,0,0,0,0,0,0));
    rd(2'd0, 3'd2, v); check("R10 fill after reset", v, 32'd0);
    rd(2'd0, 3'd1, v); check("R10 control after reset", v, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule